// File: doc/BRIEF.md
# Shared Interrupt Line Steering Router

This block takes interrupt requests from a set of expansion cards and from two motherboard interrupt sources and steers each one onto one of sixteen legacy interrupt lines. Six routing registers decide the steering. Four of them are link entries shared by the card pins. The other two belong to the motherboard sources. Each entry holds a line number and a disable bit. A card's pin picks its link entry by rotation, so pin A of different slots lands on different links.

Two trigger styles are supported. A level request records the requester in a per-line hold mask, and the line output stays high while any bit of that mask is set, so cards and motherboard sources can share a line. An edge request produces a one-cycle pulse on the line and leaves the hold mask untouched. Card requests are all level when steering is enabled and all edge when it is disabled. Each motherboard request carries its own trigger flag with every set and clear. The block processes one request per cycle through a single set/clear channel. When set and clear are both raised in one cycle, the clear is applied first and the set second.

Top module: `irq_steer_router`

## Requirements
- R1: After reset both output vectors are zero and all six routing entries are disabled, so no request changes any output until an entry is written.
- R2: A write with `cfg_we` stores `cfg_data` in entry `cfg_addr`. Entries 0 to 3 are links A to D, and entries 4 and 5 belong to motherboard sources 0 and 1. Bit 7 set disables the entry, bits 3:0 give the line number, and addresses 6 and 7 are ignored. A write affects requests from the following cycle onward.
- R3: A card request uses link entry (card + pin) mod 4, with pin 0 to 3 meaning A to D.
- R4: With `steer_en` high, a card set is level-triggered. It sets hold bit `card` of its line on the next edge, and `irq_level` for that line is high from the edge after that.
- R5: With `steer_en` low, a card set raises `irq_pulse` for its line for exactly one cycle, starting one edge after the request, and leaves the hold masks unchanged. At most one pulse bit is high at a time.
- R6: A motherboard source n (n = 0 or 1) uses hold bit 30+n. Its `req_mirq_level` flag selects level handling (1) or edge handling (0) for that set or clear.
- R7: A level set from a source that already holds the line changes nothing. A shared line stays high until every holder has cleared, and it falls one cycle after its hold mask becomes empty.
- R8: A level clear from a source that does not hold the line is ignored. A level clear from a holder removes only that source's hold bit.
- R9: An edge set pulses its line every time, even while level holders keep the line high.
- R10: A motherboard index of 2 or 3, a disabled entry, or a card number at or above `NUM_CARDS` makes both set and clear have no effect.
- R11: When set and clear arrive together, the clear is applied first, so a level source ends up holding the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| steer_en | input | 1 | Steering enabled: card requests are level when high, edge when low |
| cfg_we | input | 1 | Routing register write strobe |
| cfg_addr | input | 3 | Routing entry index |
| cfg_data | input | 8 | Entry value: bit 7 disable, bits 3:0 line |
| req_set | input | 1 | Raise request from the addressed source |
| req_clr | input | 1 | Withdraw request from the addressed source |
| req_is_mirq | input | 1 | Source is a motherboard source rather than a card |
| req_card | input | CARD_W | Card number |
| req_pin | input | 2 | Card interrupt pin, 0 to 3 |
| req_mirq_sel | input | 2 | Motherboard source index |
| req_mirq_level | input | 1 | Trigger flag for a motherboard request: 1 level, 0 edge |
| irq_level | output | 16 | Level outputs, one per line |
| irq_pulse | output | 16 | One-cycle edge pulses, one per line |

## Verification
A hold bit that is wrongly set or lost cannot be seen while another holder keeps the line high. It shows up at `irq_level` only one cycle after the last legitimate holder clears, when the line either stays high or falls early. The bench therefore checks every cycle against its own hold-mask model and uses directed sequences in which shared holders release in turn. A wrong route or a wrong trigger decision shows up within two edges, as a pulse or level on the wrong line or as a pulse where a level was expected.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int LINES     = 16;
    localparam int LINE_W    = 4;
    localparam int MASK_W    = 32;
    localparam int SRC_W     = 5;
    localparam int MIRQ_BASE = 30;
    localparam int N_LINK    = 4;
    localparam int N_MIRQ    = 2;
    localparam int N_ROUTE   = N_LINK + N_MIRQ;

    typedef struct packed {
        logic              dis;
        logic [2:0]        unused;
        logic [LINE_W-1:0] line;
    } route_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_steer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [2:0]          addr,
    input  logic [7:0]          wdata,
    output route_t [N_ROUTE-1:0] routes
);
    route_t [N_ROUTE-1:0] regs_q;

    for (genvar e = 0; e < N_ROUTE; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[e] <= route_t'(8'h80);
            else if (we && addr == 3'(e))
                regs_q[e] <= route_t'(wdata);
        end
    end

    assign routes = regs_q;
endmodule

// File: rtl/irq_req_decode.sv
module irq_req_decode
    import irq_steer_pkg::*;
#(
    parameter int NUM_CARDS = 8,
    parameter int CARD_W    = 3
) (
    input  route_t [N_ROUTE-1:0] routes,
    input  logic                 steer_en,
    input  logic                 is_mirq,
    input  logic [CARD_W-1:0]    card,
    input  logic [1:0]           pin,
    input  logic [1:0]           mirq_sel,
    input  logic                 mirq_level,
    output logic                 ok,
    output logic [LINE_W-1:0]    line,
    output logic [SRC_W-1:0]     src,
    output logic                 is_level
);
    logic [2:0] entry;
    logic [1:0] link;
    route_t     sel_route;

    always_comb begin
        link     = 2'(card) + pin;
        entry    = is_mirq ? (3'(N_LINK) + {2'b00, mirq_sel[0]}) : {1'b0, link};
        sel_route = routes[entry];
        line     = sel_route.line;
        src      = is_mirq ? SRC_W'(MIRQ_BASE + int'(mirq_sel[0])) : SRC_W'(card);
        is_level = is_mirq ? mirq_level : steer_en;
        ok       = !sel_route.dis;
        if (is_mirq && mirq_sel[1])
            ok = 1'b0;
        if (!is_mirq && int'(card) >= NUM_CARDS)
            ok = 1'b0;
    end
endmodule

// File: rtl/irq_hold_array.sv
module irq_hold_array
    import irq_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_v,
    input  logic              clr_v,
    input  logic              is_level,
    input  logic [LINE_W-1:0] line,
    input  logic [SRC_W-1:0]  src,
    output logic [LINES-1:0]  level_out,
    output logic [LINES-1:0]  pulse_out
);
    logic [LINES-1:0][MASK_W-1:0] hold_q;
    logic [LINES-1:0][MASK_W-1:0] hold_d;
    logic [LINES-1:0]             level_q, pulse_q;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_comb begin
            hold_d[g] = hold_q[g];
            if (line == LINE_W'(g) && is_level) begin
                if (clr_v) hold_d[g][src] = 1'b0;   // clear first
                if (set_v) hold_d[g][src] = 1'b1;   // then set
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[g]  <= '0;
                level_q[g] <= 1'b0;
                pulse_q[g] <= 1'b0;
            end else begin
                hold_q[g]  <= hold_d[g];
                level_q[g] <= |hold_q[g];
                pulse_q[g] <= set_v && !is_level && line == LINE_W'(g);
            end
        end
    end

    assign level_out = level_q;
    assign pulse_out = pulse_q;

    // Flat view: index {line, src} works because MASK_W is a power of two.
    logic [LINES*MASK_W-1:0]     hold_flat;
    logic [LINE_W+SRC_W-1:0]     flat_idx;
    assign hold_flat = hold_q;
    assign flat_idx  = {line, src};

    assert_level_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v && is_level) |=> hold_flat[$past(flat_idx)]);
    assert_level_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v && !set_v && is_level) |=> !hold_flat[$past(flat_idx)]);
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v && set_v && is_level) |=> hold_flat[$past(flat_idx)]);
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_v && !clr_v) |=> $stable(hold_flat));
    assert_edge_no_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level) |=> $stable(hold_flat));
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_q));
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_steer_pkg::*;
#(
    parameter int NUM_CARDS = 8,
    parameter int CARD_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              steer_en,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_data,
    input  logic              req_set,
    input  logic              req_clr,
    input  logic              req_is_mirq,
    input  logic [CARD_W-1:0] req_card,
    input  logic [1:0]        req_pin,
    input  logic [1:0]        req_mirq_sel,
    input  logic              req_mirq_level,
    output logic [LINES-1:0]  irq_level,
    output logic [LINES-1:0]  irq_pulse
);
    route_t [N_ROUTE-1:0] routes;
    logic              ok, is_level;
    logic [LINE_W-1:0] line;
    logic [SRC_W-1:0]  src;

    irq_route_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_data), .routes(routes)
    );

    irq_req_decode #(.NUM_CARDS(NUM_CARDS), .CARD_W(CARD_W)) u_dec (
        .routes(routes), .steer_en(steer_en), .is_mirq(req_is_mirq),
        .card(req_card), .pin(req_pin), .mirq_sel(req_mirq_sel),
        .mirq_level(req_mirq_level), .ok(ok), .line(line), .src(src),
        .is_level(is_level)
    );

    irq_hold_array u_hold (
        .clk(clk), .rst_n(rst_n), .set_v(req_set && ok), .clr_v(req_clr && ok),
        .is_level(is_level), .line(line), .src(src),
        .level_out(irq_level), .pulse_out(irq_pulse)
    );

    assert_pulse_from_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse != '0) |-> $past(req_set));
    assert_rejected_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_is_mirq && req_mirq_sel[1]) |=> (irq_pulse == '0));
endmodule

// File: tb/irq_steer_router_tb_top.sv
`timescale 1ns/1ps
module irq_steer_router_tb_top;
    localparam int NC = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic steer_en = 0, cfg_we = 0, req_set = 0, req_clr = 0, req_is_mirq = 0, req_mirq_level = 0;
    logic [2:0] cfg_addr = 0, req_card = 0;
    logic [7:0] cfg_data = 0;
    logic [1:0] req_pin = 0, req_mirq_sel = 0;
    logic [15:0] irq_level, irq_pulse;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [7:0]  m_route [6];
    logic [31:0] m_hold  [16];
    logic [15:0] m_level, m_pulse;

    always #2 clk = ~clk;

    irq_steer_router #(.NUM_CARDS(NC), .CARD_W(3)) dut_i (.*);

    function automatic int entry_of(logic mirq, logic [2:0] card, logic [1:0] pin, logic [1:0] sel);
        return mirq ? 4 + int'(sel[0]) : (int'(card) + int'(pin)) % 4;
    endfunction

    // Reference update applied at each clock edge, using pre-edge inputs.
    function automatic void model_edge();
        int e, ln, s;
        logic lvl, ok;
        for (int i = 0; i < 16; i++) m_level[i] = (m_hold[i] != 0);
        m_pulse = '0;
        e   = entry_of(req_is_mirq, req_card, req_pin, req_mirq_sel);
        ln  = int'(m_route[e][3:0]);
        s   = req_is_mirq ? 30 + int'(req_mirq_sel[0]) : int'(req_card);
        lvl = req_is_mirq ? req_mirq_level : steer_en;
        ok  = !m_route[e][7] && !(req_is_mirq && req_mirq_sel[1]) && (req_is_mirq || int'(req_card) < NC);
        if (ok) begin
            if (lvl) begin
                if (req_clr) m_hold[ln][s] = 1'b0;
                if (req_set) m_hold[ln][s] = 1'b1;
            end else if (req_set) m_pulse[ln] = 1'b1;
        end
        if (cfg_we && cfg_addr < 6) m_route[cfg_addr] = cfg_data;
    endfunction

    task automatic check(string tag);
        n_cmp++;
        if (irq_level !== m_level || irq_pulse !== m_pulse) begin
            n_bad++;
            $display("FAIL %s: level=%h pulse=%h expected level=%h pulse=%h",
                     tag, irq_level, irq_pulse, m_level, m_pulse);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk); #0.5;
        model_edge();
        @(negedge clk);
        check(tag);
        cfg_we = 0; req_set = 0; req_clr = 0;
    endtask

    task automatic wr(int a, logic [7:0] d, string tag);
        cfg_we = 1; cfg_addr = 3'(a); cfg_data = d; step(tag);
    endtask

    task automatic card(logic s, logic c, int cd, int p, string tag);
        req_is_mirq = 0; req_set = s; req_clr = c; req_card = 3'(cd); req_pin = 2'(p); step(tag);
    endtask

    task automatic mirq(logic s, logic c, int n, logic lv, string tag);
        req_is_mirq = 1; req_set = s; req_clr = c; req_mirq_sel = 2'(n); req_mirq_level = lv; step(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: level=%h pulse=%h expected completion", irq_level, irq_pulse);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 6; i++) m_route[i] = 8'h80;
        for (int i = 0; i < 16; i++) m_hold[i] = '0;
        m_level = '0; m_pulse = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 reset outputs");
        steer_en = 1;
        card(1, 0, 0, 0, "R1 disabled route ignores set");
        step("R1 level stays low");
        // R2: program links and motherboard entries; addr 6 ignored
        wr(0, 8'h05, "R2 write link A");
        wr(1, 8'h07, "R2 write link B");
        wr(2, 8'h0A, "R2 write link C");
        wr(3, 8'h0B, "R2 write link D");
        wr(4, 8'h05, "R2 write mirq0");
        wr(5, 8'h8E, "R2 write mirq1 disabled");
        wr(6, 8'h03, "R2 addr 6 ignored");
        // R3/R4: card 1 pin 1 -> link C -> line 10, level
        card(1, 0, 1, 1, "R3 R4 card1 pinB set");
        step("R4 level high after two edges");
        card(1, 0, 1, 1, "R7 repeat set no change");
        // R6: mirq0 level shares line 5 with card 0 pin A
        card(1, 0, 0, 0, "R4 card0 on line 5");
        mirq(1, 0, 0, 1, "R6 mirq0 level hold");
        card(0, 1, 0, 0, "R7 card0 clears, mirq0 still holds");
        step("R7 shared line stays high");
        mirq(0, 1, 1, 1, "R10 disabled mirq1 clear ignored");
        mirq(1, 1, 2, 1, "R10 mirq index 2 rejected");
        card(0, 1, 2, 0, "R8 clear from non-holder ignored");
        mirq(1, 0, 0, 0, "R9 edge pulse on held line");
        mirq(0, 1, 0, 1, "R7 last holder clears");
        step("R7 line falls one cycle later");
        step("R7 line low");
        // R5: edge cards
        steer_en = 0;
        card(1, 0, 3, 0, "R5 edge card pulse");
        step("R5 pulse lasts one cycle");
        card(1, 1, 3, 0, "R5 edge set with clear");
        // R11
        steer_en = 1;
        card(1, 1, 2, 2, "R11 set and clear together");
        step("R11 source holds");
        card(0, 1, 2, 2, "R8 holder clear");
        card(1, 0, 7, 3, "R10 card above NUM_CARDS ignored? none with NC=8");
        // random phase
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                cfg_we = 1; cfg_addr = 3'($urandom_range(0, 7));
                cfg_data = {($urandom_range(0, 5) == 0), 3'b000, 4'($urandom)};
            end
            if ($urandom_range(0, 15) == 0) steer_en = ~steer_en;
            req_set = 1'($urandom); req_clr = 1'($urandom);
            req_is_mirq = ($urandom_range(0, 2) == 0);
            req_card = 3'($urandom); req_pin = 2'($urandom);
            req_mirq_sel = 2'($urandom); req_mirq_level = 1'($urandom);
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule